// File: doc/BRIEF.md
# Binary Antilogarithm Approximation Converter

This block turns a fixed-point base-two logarithm back into an unsigned integer. The log value arrives as two fields: an integer characteristic `k` and a binary fraction `x` in the range 0 <= x < 1. The output approximates 2^k * (1 + x) with the piecewise-linear inverse rule. No exponent table is involved. A decoder sets a single one at bit `k`. The fraction field is shifted left by `k`, which puts its most significant bit directly below that leading one. The two vectors are then ORed together.

The converter is purely combinational. It is meant to sit after the adder of a logarithmic multiplier, where two N-bit operands give a product of 2N bits. The fraction keeps at least N-1 bits. The characteristic is just wide enough to address every bit of the 2N-bit result, which makes N a power of two. Any fraction bit that lands below the integer binary point is dropped without rounding.

Top module: `alog_convert`

## Requirements
- R1: With a zero fraction, the output is exactly 2^k: a single one at bit position `k` and zeros elsewhere, for every `k` from 0 to 2N-1.
- R2: For any fraction, the output equals 2^k + floor(x * 2^k). The fraction's most significant bit (bit FRAC_W-1, weight 1/2) lands at bit k-1, directly below the leading one, and lower fraction bits follow in order.
- R3: Fraction bits that would land below bit 0 are discarded with no rounding. With `k` = 0 the output is 1 whatever the fraction, and with `k` = 3 and an all-ones 7-bit fraction the output is 15.
- R4: A characteristic of 4 with fraction bits 1001 followed by zeros (0.5625) gives 25 (binary 11001).
- R5: A characteristic of 0 with a zero fraction gives an output of 1.
- R6: At the largest characteristic (2N-1) no bit wraps or is lost from the top. With N = 8, `k` = 15 and an all-ones 7-bit fraction the output is 0xFF00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| log_char | input | $clog2(2N) (4) | Integer characteristic `k` of the log value |
| log_frac | input | FRAC_W (7) | Binary fraction `x`, MSB has weight 1/2 |
| lin_out | output | 2N (16) | Reconstructed integer, about 2^k * (1 + x) |

## Verification
The bench walks the leading one across every characteristic with a zero fraction. A decoder that is off by one position, or that sets two bits, shows up there at once. Small characteristics with full fractions test truncation. A design that rounds, or that lets low fraction bits leak into bit 0, returns 2 or 16 where the bench expects 1 or 15. The largest characteristic with an all-ones fraction catches a shifter that is too narrow and so wraps or loses the top fraction bits. A sweep over all characteristics with several fraction patterns compares against the arithmetic form 2^k + floor(x * 2^k), which catches a fraction that is misaligned by one bit.

// File: rtl/alog_pkg.sv
package alog_pkg;

  // Shift distance applied by barrel stage s.
  function automatic int unsigned stage_step(input int unsigned s);
    return 32'd1 << s;
  endfunction

  // Width of the characteristic needed to address every output bit.
  function automatic int unsigned char_bits(input int unsigned out_w);
    return (out_w <= 1) ? 1 : $clog2(out_w);
  endfunction

endpackage

// File: rtl/alog_lead_dec.sv
module alog_lead_dec #(
  parameter int unsigned OUT_W  = 16,
  parameter int unsigned CHAR_W = 4
) (
  input  logic [CHAR_W-1:0] char_i,
  output logic [OUT_W-1:0]  lead_o
);

  for (genvar i = 0; i < OUT_W; i++) begin : g_pos
    assign lead_o[i] = (char_i == CHAR_W'(i));
  end

  // R1: exactly one leading bit for every in-range characteristic
  always_comb begin
    a_r1_one_lead : assert ($onehot(lead_o))
      else $error("lead decoder not one-hot for k=%0d", char_i);
  end

endmodule

// File: rtl/alog_frac_align.sv
module alog_frac_align
  import alog_pkg::*;
#(
  parameter int unsigned OUT_W  = 16,
  parameter int unsigned FRAC_W = 7,
  parameter int unsigned CHAR_W = 4
) (
  input  logic [CHAR_W-1:0] char_i,
  input  logic [FRAC_W-1:0] frac_i,
  output logic [OUT_W-1:0]  field_o,
  output logic [FRAC_W-1:0] dropped_o
);

  localparam int unsigned WIDE = OUT_W + FRAC_W;

  logic [WIDE-1:0] stg [0:CHAR_W];

  assign stg[0] = {{OUT_W{1'b0}}, frac_i};

  for (genvar s = 0; s < CHAR_W; s++) begin : g_stage
    localparam int unsigned STEP = stage_step(s);
    assign stg[s+1] = char_i[s] ? (stg[s] << STEP) : stg[s];
  end

  // Integer part of the shifted fraction, and the bits cut off below bit 0.
  assign field_o   = stg[CHAR_W][WIDE-1:FRAC_W];
  assign dropped_o = stg[CHAR_W][FRAC_W-1:0];

  // R2: shifting conserves the ones of the fraction (no wrap inside the window)
  always_comb begin
    a_r2_bits_conserved : assert ($countones(stg[CHAR_W]) == $countones(frac_i))
      else $error("aligner lost fraction bits at k=%0d", char_i);
  end

endmodule

// File: rtl/alog_merge.sv
module alog_merge #(
  parameter int unsigned OUT_W = 16
) (
  input  logic [OUT_W-1:0] lead_i,
  input  logic [OUT_W-1:0] field_i,
  output logic [OUT_W-1:0] result_o
);

  logic [OUT_W-1:0] below_lead;

  assign below_lead = lead_i - OUT_W'(1);
  assign result_o   = lead_i | field_i;

  // R2: fraction bits sit strictly below the leading one
  always_comb begin
    a_r2_frac_under_lead : assert ((field_i & ~below_lead) == '0)
      else $error("fraction field reaches the leading bit");
  end

endmodule

// File: rtl/alog_convert.sv
module alog_convert
  import alog_pkg::*;
#(
  parameter int unsigned N      = 8,
  parameter int unsigned FRAC_W = N - 1,
  localparam int unsigned OUT_W  = 2 * N,
  localparam int unsigned CHAR_W = char_bits(OUT_W)
) (
  input  logic [CHAR_W-1:0] log_char,
  input  logic [FRAC_W-1:0] log_frac,
  output logic [OUT_W-1:0]  lin_out
);

  logic [OUT_W-1:0]  lead_bit;
  logic [OUT_W-1:0]  frac_field;
  logic [FRAC_W-1:0] frac_dropped;

  alog_lead_dec #(
    .OUT_W (OUT_W),
    .CHAR_W(CHAR_W)
  ) u_dec (
    .char_i(log_char),
    .lead_o(lead_bit)
  );

  alog_frac_align #(
    .OUT_W (OUT_W),
    .FRAC_W(FRAC_W),
    .CHAR_W(CHAR_W)
  ) u_align (
    .char_i   (log_char),
    .frac_i   (log_frac),
    .field_o  (frac_field),
    .dropped_o(frac_dropped)
  );

  alog_merge #(
    .OUT_W(OUT_W)
  ) u_merge (
    .lead_i  (lead_bit),
    .field_i (frac_field),
    .result_o(lin_out)
  );

  always_comb begin
    // R3: at k = 0 every fraction bit is cut off and only the leading one remains
    if (log_char == '0) begin
      a_r3_truncate_all : assert (frac_dropped == log_frac && lin_out == OUT_W'(1))
        else $error("k=0 did not truncate the fraction");
    end
    // R1 / R5: a zero fraction yields a pure power of two at position k
    if (log_frac == '0) begin
      a_r1_pure_power : assert (lin_out == lead_bit && $onehot(lin_out))
        else $error("zero fraction gave non power of two");
    end
    // R6: the leading one always stays the top set bit of the output
    a_r6_top_bit : assert ((lin_out >> log_char) == OUT_W'(1))
      else $error("output top bit not at k=%0d", log_char);
  end

endmodule

// File: tb/sim_alog_convert.sv
module sim_alog_convert;

  localparam int unsigned N      = 8;
  localparam int unsigned FRAC_W = N - 1;
  localparam int unsigned OUT_W  = 2 * N;
  localparam int unsigned CHAR_W = $clog2(OUT_W);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [CHAR_W-1:0] log_char = '0;
  logic [FRAC_W-1:0] log_frac = '0;
  logic [OUT_W-1:0]  lin_out;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  alog_convert #(.N(N)) u0 (
    .log_char(log_char),
    .log_frac(log_frac),
    .lin_out (lin_out)
  );

  // Arithmetic model: 2^k + floor(x * 2^k), x = frac / 2^FRAC_W
  function automatic longint model(input int k, input int frac);
    longint whole;
    longint part;
    whole = longint'(1) << k;
    part  = (longint'(frac) * whole) / (longint'(1) << FRAC_W);
    return (whole + part) & ((longint'(1) << OUT_W) - 1);
  endfunction

  task automatic apply(input int k, input int frac);
    @(negedge clk);
    log_char = CHAR_W'(k);
    log_frac = FRAC_W'(frac);
    #1;
  endtask

  task automatic check(input string req, input longint got, input longint exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s k=%0d frac=0x%0h got=0x%0h exp=0x%0h",
               req, log_char, log_frac, got, exp);
    end
  endtask

  task automatic t_reset_state();
    apply(0, 0);
    check("R5", lin_out, 1);
  endtask

  task automatic t_powers();
    for (int k = 0; k < OUT_W; k++) begin
      apply(k, 0);
      check("R1", lin_out, longint'(1) << k);
    end
  endtask

  task automatic t_example();
    apply(4, 7'b1001000);
    check("R4", lin_out, 25);
  endtask

  task automatic t_truncation();
    apply(0, 7'h7F);
    check("R3", lin_out, 1);
    apply(0, 7'h40);
    check("R3", lin_out, 1);
    apply(3, 7'h7F);
    check("R3", lin_out, 15);
    apply(1, 7'h3F);
    check("R3", lin_out, 2);
  endtask

  task automatic t_placement();
    apply(7, 7'h40);
    check("R2", lin_out, 192);
    apply(7, 7'h01);
    check("R2", lin_out, 129);
    apply(8, 7'h01);
    check("R2", lin_out, 258);
  endtask

  task automatic t_top();
    apply(OUT_W - 1, 7'h7F);
    check("R6", lin_out, 16'hFF00);
    apply(OUT_W - 1, 7'h40);
    check("R6", lin_out, 16'hC000);
  endtask

  task automatic t_sweep();
    int pats [6] = '{7'h00, 7'h7F, 7'h55, 7'h2A, 7'h01, 7'h40};
    for (int k = 0; k < OUT_W; k++) begin
      for (int p = 0; p < 6; p++) begin
        apply(k, pats[p]);
        check("R2", lin_out, model(k, pats[p]));
      end
    end
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    t_reset_state();
    t_powers();
    t_example();
    t_truncation();
    t_placement();
    t_top();
    t_sweep();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule